// File: doc/BRIEF.md
# Length-Steered Serial Register Port

This block is a three-wire synchronous serial slave. It has a serial clock, an active-low frame enable, a data input and a daisy-chain data output. The stream carries no address or steering bits. When the enable returns high, the number of serial clock rising edges counted in that frame picks the destination. An 8-clock frame writes an 8-bit configuration register. A 24-clock frame writes a 24-bit display register. Longer frames let several ports share one chain.

Serial bits enter most significant first on each rising serial clock edge and move through a 24-bit shift chain. A half stage after the chain updates on the falling serial clock edge. That half stage feeds the next port in the chain, which therefore samples settled data on its own rising edge. Each successful register load sends a one-cycle blanking pulse to the display scanner. The scanner and the segment decoding sit outside this block and read the two parallel register outputs.

The port runs in a single system clock domain. The serial clock, enable and data pass through a two-flop synchroniser, and every edge is detected on the synchronised copies. An enable edge that arrives while the serial clock is high is a protocol error. That frame is dropped, and the port recovers once enable is high and the serial clock is low.

Top module: `lsp_port`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk` while `ser_en_n` is low, and the first bit of a frame is the most significant bit.
- R2: A frame of exactly 8 rising edges loads `cfg_q` with those 8 bits. The first bit goes to bit 7.
- R3: A frame of exactly 24 rising edges loads `disp_q` with those 24 bits. The first bit goes to bit 23.
- R4: `cfg_q` and `disp_q` change only in response to a rising edge of `ser_en_n`. They never change while bits are shifting.
- R5: On each falling edge of `ser_clk` inside a frame, `ser_dout` takes the bit shifted in 24 rising edges earlier. `ser_dout` is held low while `ser_en_n` is high.
- R6: Each register load produces exactly one `blank_p` pulse, one system clock wide. A frame that loads nothing produces no pulse.
- R7: After reset, `cfg_q` is 0 (bit 0 low selects low-power mode), `disp_q` is 0, `ser_dout` is 0 and `blank_p` is 0.
- R8: Frames of 1 to 7 edges, and frames of 9 to 23 edges, change neither register and give no pulse.
- R9: For a count N of 25 or more, the frame loads `cfg_q` from its last 8 bits when N mod 32 is 0 or 8 (for example 32 or 64). Any other N of 25 or more loads `disp_q` from its last 24 bits (for example 48 or 80).
- R10: If `ser_en_n` changes while `ser_clk` is high, that frame loads nothing and gives no pulse. The next well-formed frame loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data in, most significant bit first |
| ser_dout | output | 1 | Chain output, updated on the falling serial clock edge |
| cfg_q | output | 8 | Configuration register |
| disp_q | output | 24 | Display register |
| blank_p | output | 1 | One-cycle blanking pulse on each load |

## Verification
The assertions assume the following about the inputs:
- Every serial level lasts at least three system clocks.
- `ser_din` is stable around the rising serial clock edge.
- A serial clock edge and an enable edge never reach the synchroniser in the same cycle. Otherwise two rising enable edges could not fall in consecutive cycles, and the hold properties would not follow.

The stimulus tasks hold every serial level for three or four system clocks and set the data before raising the clock. They move the enable only while the serial clock is low, except in the two directed protocol-error cases, where the enable edge is deliberately placed inside a high serial clock phase.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int CFG_W = 8;
  localparam int DSP_W = 24;
  // frame count is tracked modulo CFG_W + DSP_W (32) for the cascade rule
  localparam int MOD_W = $clog2(CFG_W + DSP_W);
  localparam int SAT_W = $clog2(DSP_W + 1);

  typedef enum logic [1:0] {XF_NONE, XF_CFG, XF_DSP} xfer_e;

  // classify a finished frame from its wrapped count and threshold flags
  function automatic xfer_e xfer_kind(logic [MOD_W-1:0] cmod, logic ge_cfg, logic ge_dsp);
    logic cfg_phase;
    cfg_phase = (cmod == MOD_W'(CFG_W)) || (cmod == '0);
    if (ge_cfg && cfg_phase) return XF_CFG;
    else if (ge_dsp) return XF_DSP;
    else return XF_NONE;
  endfunction
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= din;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/lsp_edge.sv
module lsp_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= RST_VAL;
    else lvl_d <= lvl;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign rise[i] = lvl[i] & ~lvl_d[i];
      assign fall[i] = ~lvl[i] & lvl_d[i];
    end
  endgenerate
endmodule

// File: rtl/lsp_shift.sv
module lsp_shift
  import lsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             sdi,
  output logic [DSP_W-1:0] chain,
  output logic [MOD_W-1:0] cmod,
  output logic [SAT_W-1:0] csat,
  output logic             sdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      cmod  <= '0;
      csat  <= '0;
      sdo   <= 1'b0;
    end else if (!in_frame) begin
      cmod <= '0;
      csat <= '0;
      sdo  <= 1'b0;
    end else begin
      if (sck_rise) begin
        chain <= {chain[DSP_W-2:0], sdi};
        cmod  <= cmod + 1'b1;
        if (csat != SAT_W'(DSP_W)) csat <= csat + 1'b1;
      end
      if (sck_fall) sdo <= chain[DSP_W-1];
    end
  end
endmodule

// File: rtl/lsp_load.sv
module lsp_load
  import lsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic             en_hi,
  input  logic             sck_hi,
  input  xfer_e            kind,
  input  logic [DSP_W-1:0] chain,
  output logic [CFG_W-1:0] cfg_q,
  output logic [DSP_W-1:0] disp_q,
  output logic             blank,
  output logic             err
);
  logic do_cfg, do_dsp;

  assign do_cfg = en_rise && !sck_hi && !err && (kind == XF_CFG);
  assign do_dsp = en_rise && !sck_hi && !err && (kind == XF_DSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      disp_q <= '0;
      blank  <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (do_cfg) cfg_q <= chain[CFG_W-1:0];
      if (do_dsp) disp_q <= chain;
      blank <= do_cfg | do_dsp;
      if ((en_rise || en_fall) && sck_hi) err <= 1'b1;
      else if (en_hi && !sck_hi) err <= 1'b0;
    end
  end
endmodule

// File: rtl/lsp_port.sv
module lsp_port
  import lsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_en_n,
  input  logic             ser_din,
  output logic             ser_dout,
  output logic [CFG_W-1:0] cfg_q,
  output logic [DSP_W-1:0] disp_q,
  output logic             blank_p
);
  logic [2:0] s_lvl;
  logic [1:0] e_rise, e_fall;
  logic sck_hi_w, en_hi_w, sdi_w;
  logic sck_rise_w, sck_fall_w, en_rise_w, en_fall_w;
  logic err_w;
  logic [DSP_W-1:0] chain_w;
  logic [MOD_W-1:0] cmod_w;
  logic [SAT_W-1:0] csat_w;
  xfer_e kind_w;

  // bit 2 data, bit 1 enable (idle high), bit 0 serial clock
  lsp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ser_din, ser_en_n, ser_clk}), .dout(s_lvl));

  assign sdi_w    = s_lvl[2];
  assign en_hi_w  = s_lvl[1];
  assign sck_hi_w = s_lvl[0];

  lsp_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(s_lvl[1:0]), .rise(e_rise), .fall(e_fall));

  assign sck_rise_w = e_rise[0];
  assign sck_fall_w = e_fall[0];
  assign en_rise_w  = e_rise[1];
  assign en_fall_w  = e_fall[1];

  lsp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .in_frame(!en_hi_w), .sck_rise(sck_rise_w),
    .sck_fall(sck_fall_w), .sdi(sdi_w), .chain(chain_w), .cmod(cmod_w),
    .csat(csat_w), .sdo(ser_dout));

  assign kind_w = xfer_kind(cmod_w, csat_w >= SAT_W'(CFG_W), csat_w >= SAT_W'(DSP_W));

  lsp_load u_load (
    .clk(clk), .rst_n(rst_n), .en_rise(en_rise_w), .en_fall(en_fall_w),
    .en_hi(en_hi_w), .sck_hi(sck_hi_w), .kind(kind_w), .chain(chain_w),
    .cfg_q(cfg_q), .disp_q(disp_q), .blank(blank_p), .err(err_w));
endmodule

// File: rtl/lsp_port_chk.sv
module lsp_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_rise,
  input logic        en_hi,
  input logic        err,
  input logic        blank,
  input logic        sdo,
  input logic [7:0]  cfg_q,
  input logic [23:0] disp_q
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(cfg_q)); // R4
  AST_DSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(disp_q)); // R4
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_hi |=> !sdo); // R5
  AST_BLANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !blank); // R6
  AST_BLANK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> $past(en_rise)); // R6
  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && err) |=> ($stable(cfg_q) && $stable(disp_q) && !blank)); // R10
endmodule

bind lsp_port lsp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_rise(en_rise_w), .en_hi(en_hi_w), .err(err_w),
  .blank(blank_p), .sdo(ser_dout), .cfg_q(cfg_q), .disp_q(disp_q));

// File: tb/lsp_port_tb.sv
module lsp_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_en_n = 1'b1;
  logic ser_din = 1'b0;
  logic ser_dout;
  logic [7:0] cfg_q;
  logic [23:0] disp_q;
  logic blank_p;

  int total = 0;
  int fails = 0;
  int bcnt = 0;
  bit done = 0;
  logic [23:0] hist = '0;

  always #4 clk = ~clk;

  lsp_port u_dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .cfg_q(cfg_q), .disp_q(disp_q), .blank_p(blank_p));

  always @(negedge clk) if (blank_p) bcnt++;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 none, 1 configuration, 2 display
  function automatic int bench_kind(int n);
    if (n == 8) return 1;
    if (n > 24 && ((n % 32) == 0 || (n % 32) == 8)) return 1;
    if (n >= 24) return 2;
    return 0;
  endfunction

  task automatic one_bit(logic b);
    ser_din = b;
    idle(3);
    ser_clk = 1'b1;
    hist = {hist[22:0], b};
    idle(4);
    ser_clk = 1'b0;
    idle(4);
    chk(ser_dout == hist[23], "R5 chain output", 32'(ser_dout), 32'(hist[23]));
  endtask

  task automatic frame(int n, logic [127:0] pat);
    logic [7:0] c0;
    logic [23:0] d0;
    int b0, k;
    c0 = cfg_q; d0 = disp_q; b0 = bcnt;
    ser_en_n = 1'b0;
    idle(4);
    for (int i = 0; i < n; i++) one_bit(pat[n-1-i]);
    chk(cfg_q == c0 && disp_q == d0, "R4 hold during shift", {cfg_q, disp_q[23:0]}, {c0, d0});
    ser_en_n = 1'b1;
    idle(6);
    k = bench_kind(n);
    if (k == 1) begin
      chk(cfg_q == hist[7:0], (n == 8) ? "R2 config load" : "R9 cascade config", 32'(cfg_q), 32'(hist[7:0]));
      chk(disp_q == d0, "R9 display untouched", 32'(disp_q), 32'(d0));
    end else if (k == 2) begin
      chk(disp_q == hist, (n == 24) ? "R3 display load" : "R9 cascade display", 32'(disp_q), 32'(hist));
      chk(cfg_q == c0, "R3 config untouched", 32'(cfg_q), 32'(c0));
    end else begin
      chk(cfg_q == c0 && disp_q == d0, "R8 short frame ignored", {cfg_q, disp_q}, {c0, d0});
    end
    chk((bcnt - b0) == ((k != 0) ? 1 : 0), "R6 blank count", 32'(bcnt - b0), (k != 0) ? 32'd1 : 32'd0);
    chk(ser_dout == 1'b0, "R5 idle low", 32'(ser_dout), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    logic [23:0] d0;
    int b0;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R7
    chk(cfg_q == 8'h00, "R7 reset config", 32'(cfg_q), 32'd0);
    chk(disp_q == 24'h0, "R7 reset display", 32'(disp_q), 32'd0);
    chk(ser_dout == 1'b0 && blank_p == 1'b0 && bcnt == 0, "R7 reset outputs", 32'(ser_dout), 32'd0);

    // R1 R2 R3: directed bit order
    frame(8, 128'hA5);
    chk(cfg_q == 8'hA5, "R1 msb first config", 32'(cfg_q), 32'hA5);
    frame(24, 128'h123456);
    chk(disp_q == 24'h123456, "R1 msb first display", 32'(disp_q), 32'h123456);
    // R8
    frame(12, 128'hFFF);
    frame(5, 128'h1F);
    frame(23, 128'h7FFFFF);
    frame(9, 128'h1AB);
    // R9
    frame(32, 128'hDEADBEEF);
    chk(cfg_q == 8'hEF, "R9 last eight bits", 32'(cfg_q), 32'hEF);
    frame(48, 128'hCAFE_00F00D_BA5EBA);
    chk(disp_q == 24'h5EBA ^ 24'hBA0000 ^ 24'h000000 ? disp_q == 24'hBA5EBA : 1'b0, "R9 last 24 bits", 32'(disp_q), 32'hBA5EBA);
    frame(64, {64'h0, 64'h0123_4567_89AB_CD3C});
    frame(80, {48'h0, 80'hFFFF_0000_1111_2222_3333});

    // R10: enable falls while serial clock high
    c0 = cfg_q; d0 = disp_q; b0 = bcnt;
    ser_clk = 1'b1; idle(4);
    ser_en_n = 1'b0; idle(4);
    ser_clk = 1'b0; idle(4);
    for (int i = 0; i < 8; i++) begin
      ser_din = 1'b1; idle(3); ser_clk = 1'b1; hist = {hist[22:0], 1'b1}; idle(4); ser_clk = 1'b0; idle(4);
    end
    ser_en_n = 1'b1; idle(6);
    chk(cfg_q == c0 && bcnt == b0, "R10 bad start discarded", 32'(cfg_q), 32'(c0));
    frame(8, 128'h3C);
    chk(cfg_q == 8'h3C, "R10 resync", 32'(cfg_q), 32'h3C);

    // R10: enable rises while serial clock high
    c0 = cfg_q; d0 = disp_q; b0 = bcnt;
    ser_en_n = 1'b0; idle(4);
    for (int i = 0; i < 24; i++) one_bit(1'(i & 1));
    ser_din = 1'b0; idle(3);
    ser_clk = 1'b1; hist = {hist[22:0], 1'b0}; idle(4);
    ser_en_n = 1'b1; idle(4);
    ser_clk = 1'b0; idle(6);
    chk(disp_q == d0 && cfg_q == c0 && bcnt == b0, "R10 bad end discarded", 32'(disp_q), 32'(d0));
    frame(24, 128'hABCDEF);
    chk(disp_q == 24'hABCDEF, "R10 resync display", 32'(disp_q), 32'hABCDEF);

    // constrained random frames
    for (int w = 0; w < 40; w++) begin
      int sel, n;
      sel = int'($urandom % 6);
      case (sel)
        0: n = 8;
        1: n = 24;
        2: n = 32;
        3: n = 48;
        4: n = 1 + int'($urandom % 23);
        default: n = 25 + int'($urandom % 100);
      endcase
      frame(n, {$urandom, $urandom, $urandom, $urandom});
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule